// File: doc/BRIEF.md
# Split-Width Multiply-Accumulate Datapath

This block is the arithmetic core of a memory-side arithmetic accelerator for multi-precision modular multiplication. It accumulates full 32x32-bit word products into a wide accumulator. It does this with a multiplier only half as wide as one operand, so each product takes two multiply cycles. Operand words arrive one per cycle from a 32-bit data bus. A strobe captures the word into the A register. A second strobe captures it into the upper part of a 48-bit B register, which moves down by 16 bits so that the low and then the high half of B feed the multiplier in turn.

The B register is 48 bits wide so that the next B word can be loaded during the first multiply cycle of the current product while its upper half is still waiting in the low 16 bits. A new product can therefore start every second cycle. After the final accumulation of a result column, the accumulator can move down by one word. The word that drops out is held in an output register and offered on a valid/ready stream until the consumer takes it. The surrounding sequencer that issues the bus addresses is not part of this block.

Commands use a valid/ready handshake. A command is taken only in a cycle where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` does not depend on `cmd_valid` or on the command fields. The output stream follows the usual rule: once `wr_valid` is high, `wr_data` and `wr_valid` stay unchanged until a cycle with `wr_ready` high.

Top module: `split_mac_unit`

## Requirements
- R1: After reset, `wr_valid` is 0, `cmd_ready` is 1 and the accumulator holds zero, so a first word-shift emits 0.
- R2: If B is loaded (`b_ld`) in cycle t-2, A is loaded (`a_ld`) in cycle t-1 and a multiply command (`cmd_mul`=1) is accepted in cycle t, then the full 64-bit product A*B is added to the accumulator at the end of cycle t+1.
- R3: A B load in the same cycle as an accepted multiply command does not disturb that product. Products therefore issue every two cycles, with each next B loaded in the previous multiply's first cycle and each next A loaded in its second cycle.
- R4: The accumulator is 68 bits wide. Sixteen maximal products (all-ones operands) accumulate without loss, and the carries come out in later shifted words.
- R5: A multiply command with `cmd_shift`=1 loads `wr_data` with the low 32 bits of the new sum at the end of cycle t+1 and keeps the sum shifted right by 32. `wr_valid` is high from cycle t+2.
- R6: A command with `cmd_mul`=0 and `cmd_shift`=1 moves the accumulator's low 32 bits to `wr_data` and shifts the accumulator right by 32, at the end of the accepting cycle.
- R7: `cmd_clr`=1 on a multiply command makes the product replace the accumulator instead of adding to it. On a command with `cmd_mul`=0 it zeroes the accumulator after any shift in the same command.
- R8: While `wr_valid` is 1 and `wr_ready` is 0, `wr_valid` and `wr_data` stay unchanged.
- R9: `cmd_ready` is 0 in the second cycle of a multiply and while an unconsumed word waits with `wr_ready` low. Commands offered then are ignored, so an unstored word is never overwritten.
- R10: After a transfer (`wr_valid` and `wr_ready` both 1) with no new word loaded, `wr_valid` is 0 in the next cycle.
- R11: A command presented with `cmd_valid`=0 has no effect on the accumulator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_data | input | 32 | Operand word from the data bus |
| a_ld | input | 1 | Capture `bus_data` as operand A |
| b_ld | input | 1 | Capture `bus_data` into the top of the B register |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command can be accepted this cycle |
| cmd_mul | input | 1 | 1: start a multiply this cycle; 0: accumulator-only command |
| cmd_shift | input | 1 | Shift the accumulator down one word and emit the dropped word |
| cmd_clr | input | 1 | Clear: product replaces the accumulator, or zero it |
| wr_valid | output | 1 | Output word present |
| wr_ready | input | 1 | Consumer accepts the output word |
| wr_data | output | 32 | Word shifted out of the accumulator |

## Verification
Directed products with distinct high and low halves in both operands show whether the two partial products are aligned correctly and whether the B halves arrive in the right order. The back-to-back stream, with B loaded during the previous first multiply cycle, separates a correct 48-bit B register from one that drops the waiting upper half. Repeated all-ones products test the guard bits. A run with a pseudo-random consumer ready signal, mixing clears and shifts, checks that stalls never lose or duplicate a word. A hold phase offers commands while the block is not ready, to show they are refused.

// File: rtl/smu_pkg.sv
package smu_pkg;
  parameter int unsigned WORD_W  = 32;                    // operand word width
  parameter int unsigned MAX_WDS = 8;                     // words per operand
  localparam int unsigned HALF_W  = WORD_W / 2;
  localparam int unsigned GUARD_W = $clog2(2 * MAX_WDS);
  localparam int unsigned ACC_W   = 2 * WORD_W + GUARD_W;
  localparam int unsigned PROD_W  = WORD_W + HALF_W;
  localparam int unsigned BREG_W  = WORD_W + HALF_W;
endpackage

// File: rtl/smu_operand_regs.sv
module smu_operand_regs
  import smu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] bus_data,
  input  logic              a_ld,
  input  logic              b_ld,
  input  logic              mul1,
  output logic [WORD_W-1:0] opa,
  output logic [HALF_W-1:0] opb_lo
);
  logic [BREG_W-1:0] opb_q;
  logic              b_pend_q;
  logic              step;

  // B moves down one half in the cycle after its load and in the first multiply cycle
  assign step = b_pend_q | mul1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      opa      <= '0;
      opb_q    <= '0;
      b_pend_q <= 1'b0;
    end else begin
      if (a_ld) opa <= bus_data;
      b_pend_q <= b_ld;
      if (b_ld)
        opb_q <= {bus_data, (step ? opb_q[WORD_W-1:HALF_W] : opb_q[HALF_W-1:0])};
      else if (step)
        opb_q <= {{HALF_W{1'b0}}, opb_q[BREG_W-1:HALF_W]};
    end
  end

  assign opb_lo = opb_q[HALF_W-1:0];

  // upper half of the B word must be the multiplier input in the second multiply cycle
  p_bhalf_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mul1 |=> (opb_lo == $past(opb_q[WORD_W-1:HALF_W])));
endmodule

// File: rtl/smu_half_mult.sv
module smu_half_mult
  import smu_pkg::*;
#(
  parameter int unsigned STYLE = 0   // 0: inferred multiplier, 1: explicit shift-add array
) (
  input  logic [WORD_W-1:0] a,
  input  logic [HALF_W-1:0] b,
  output logic [PROD_W-1:0] p
);
  generate
    if (STYLE == 0) begin : g_infer
      assign p = PROD_W'(a) * PROD_W'(b);
    end else begin : g_array
      logic [PROD_W-1:0] rows [HALF_W];
      for (genvar i = 0; i < HALF_W; i++) begin : g_row
        assign rows[i] = b[i] ? (PROD_W'(a) << i) : '0;
      end
      always_comb begin
        p = '0;
        for (int j = 0; j < HALF_W; j++) p = p + rows[j];
      end
    end
  endgenerate
endmodule

// File: rtl/smu_accum.sv
module smu_accum
  import smu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mul1,
  input  logic              mul2,
  input  logic              mul_clr,
  input  logic              mul_shift,
  input  logic              sh_go,
  input  logic              cl_go,
  input  logic [PROD_W-1:0] prod,
  output logic              push,
  output logic [WORD_W-1:0] push_word
);
  logic [ACC_W-1:0]  acc_q;
  logic [PROD_W-1:0] part_q;
  logic [ACC_W-1:0]  full;
  logic [ACC_W-1:0]  base;
  logic [ACC_W-1:0]  sum;

  always_comb begin
    full = ACC_W'(part_q) + (ACC_W'(prod) << HALF_W);
    base = mul_clr ? '0 : acc_q;
    sum  = base + full;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q  <= '0;
      part_q <= '0;
    end else begin
      if (mul1) part_q <= prod;
      if (mul2)
        acc_q <= mul_shift ? (sum >> WORD_W) : sum;
      else if (sh_go)
        acc_q <= cl_go ? '0 : (acc_q >> WORD_W);
      else if (cl_go)
        acc_q <= '0;
    end
  end

  assign push      = (mul2 & mul_shift) | sh_go;
  assign push_word = mul2 ? sum[WORD_W-1:0] : acc_q[WORD_W-1:0];

  p_sshift_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sh_go && !cl_go && !mul2) |=> (acc_q == ($past(acc_q) >> WORD_W)));
  p_sclr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cl_go && !mul2) |=> (acc_q == '0));
  p_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!mul2 && !sh_go && !cl_go) |=> $stable(acc_q));
endmodule

// File: rtl/smu_wr_port.sv
module smu_wr_port
  import smu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_in,
  input  logic [WORD_W-1:0] load_word,
  input  logic              wr_ready,
  output logic              wr_valid,
  output logic [WORD_W-1:0] wr_data
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_valid <= 1'b0;
      wr_data  <= '0;
    end else if (load_in) begin
      wr_valid <= 1'b1;
      wr_data  <= load_word;
    end else if (wr_valid && wr_ready) begin
      wr_valid <= 1'b0;
    end
  end

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_data)));
  p_drain_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready && !load_in) |=> !wr_valid);
  p_no_clobber_r9: assert property (@(posedge clk) disable iff (!rst_n)
    load_in |-> (!wr_valid || wr_ready));
endmodule

// File: rtl/split_mac_unit.sv
module split_mac_unit
  import smu_pkg::*;
#(
  parameter int unsigned MUL_STYLE = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] bus_data,
  input  logic              a_ld,
  input  logic              b_ld,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic              cmd_mul,
  input  logic              cmd_shift,
  input  logic              cmd_clr,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [WORD_W-1:0] wr_data
);
  logic              take, mul1, sh_go, cl_go;
  logic              mul2_q, shift_q, clr_q;
  logic [WORD_W-1:0] opa;
  logic [HALF_W-1:0] opb_lo;
  logic [PROD_W-1:0] prod;
  logic              push;
  logic [WORD_W-1:0] push_word;

  // refuse in the second multiply cycle and while an unstored word would block a shift
  assign cmd_ready = !mul2_q && (!wr_valid || wr_ready);
  assign take      = cmd_valid && cmd_ready;
  assign mul1      = take && cmd_mul;
  assign sh_go     = take && !cmd_mul && cmd_shift;
  assign cl_go     = take && !cmd_mul && cmd_clr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mul2_q  <= 1'b0;
      shift_q <= 1'b0;
      clr_q   <= 1'b0;
    end else begin
      mul2_q <= mul1;
      if (mul1) begin
        shift_q <= cmd_shift;
        clr_q   <= cmd_clr;
      end
    end
  end

  smu_operand_regs u_ops (
    .clk(clk), .rst_n(rst_n), .bus_data(bus_data), .a_ld(a_ld), .b_ld(b_ld),
    .mul1(mul1), .opa(opa), .opb_lo(opb_lo)
  );

  smu_half_mult #(.STYLE(MUL_STYLE)) u_mul (
    .a(opa), .b(opb_lo), .p(prod)
  );

  smu_accum u_acc (
    .clk(clk), .rst_n(rst_n), .mul1(mul1), .mul2(mul2_q), .mul_clr(clr_q),
    .mul_shift(shift_q), .sh_go(sh_go), .cl_go(cl_go), .prod(prod),
    .push(push), .push_word(push_word)
  );

  smu_wr_port u_wr (
    .clk(clk), .rst_n(rst_n), .load_in(push), .load_word(push_word),
    .wr_ready(wr_ready), .wr_valid(wr_valid), .wr_data(wr_data)
  );

  p_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mul2_q |-> !(cmd_valid && cmd_ready));
endmodule

// File: tb/split_mac_unit_bench.sv
module split_mac_unit_bench;
  import smu_pkg::*;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [WORD_W-1:0] bus_data = '0;
  logic              a_ld = 1'b0, b_ld = 1'b0;
  logic              cmd_valid = 1'b0, cmd_mul = 1'b0, cmd_shift = 1'b0, cmd_clr = 1'b0;
  logic              cmd_ready, wr_valid;
  logic              wr_ready;
  logic [WORD_W-1:0] wr_data;

  int checks = 0;
  int fails = 0;
  logic [ACC_W-1:0]  m_acc = '0;
  logic [WORD_W-1:0] exp_q[$];
  string             tag_q[$];
  logic              rdy_mode = 1'b0;   // 0: forced, 1: pseudo-random
  logic              rdy_force = 1'b1;
  logic [15:0]       rlfsr = 16'hACE1;
  logic [31:0]       seed = 32'h1234_5677;
  int                cyc = 0;
  logic              done = 1'b0;

  always #10 clk = ~clk;   // 50 MHz

  split_mac_unit u_split_mac_unit (
    .clk(clk), .rst_n(rst_n), .bus_data(bus_data), .a_ld(a_ld), .b_ld(b_ld),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_mul(cmd_mul),
    .cmd_shift(cmd_shift), .cmd_clr(cmd_clr), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .wr_data(wr_data)
  );

  initial wr_ready = 1'b1;
  always @(posedge clk) begin
    #2;
    rlfsr    = {rlfsr[14:0], rlfsr[15] ^ rlfsr[13] ^ rlfsr[12] ^ rlfsr[10]};
    wr_ready = rdy_mode ? rlfsr[0] : rdy_force;
  end

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    #5;
    if (rst_n && wr_valid && wr_ready && !done) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R5 unexpected word", 64'(wr_data), 64'hx);
      end else begin
        logic [WORD_W-1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(wr_data == e, t, 64'(wr_data), 64'(e));
      end
    end
  end

  function automatic logic [31:0] nxt(input logic [31:0] s);
    logic [31:0] x;
    x = s ^ (s << 13);
    x = x ^ (x >> 17);
    return x ^ (x << 5);
  endfunction

  // model of one multiply command (R2, R5, R7)
  task automatic model_mul(input logic [31:0] a, input logic [31:0] b, input bit sh, input bit cl, input string tag);
    logic [ACC_W-1:0] s;
    s = (cl ? '0 : m_acc) + (ACC_W'(a) * ACC_W'(b));
    if (sh) begin
      exp_q.push_back(s[WORD_W-1:0]);
      tag_q.push_back(tag);
      m_acc = s >> WORD_W;
    end else begin
      m_acc = s;
    end
  endtask

  task automatic wait_ready();
    while (!cmd_ready) @(negedge clk);
  endtask

  task automatic mac(input logic [31:0] a, input logic [31:0] b, input bit sh, input bit cl, input string tag);
    @(negedge clk); b_ld = 1; bus_data = b;
    @(negedge clk); b_ld = 0; a_ld = 1; bus_data = a;
    @(negedge clk); a_ld = 0; bus_data = '0;
    wait_ready();
    cmd_valid = 1; cmd_mul = 1; cmd_shift = sh; cmd_clr = cl;
    model_mul(a, b, sh, cl, tag);
    @(negedge clk); cmd_valid = 0; cmd_mul = 0; cmd_shift = 0; cmd_clr = 0;
    check(cmd_ready == 1'b0, "R9 ready low in second multiply cycle", 64'(cmd_ready), 64'd0);
    if (sh && !rdy_mode) begin
      @(negedge clk);
      check(wr_valid == 1'b1, "R5 word valid two cycles after command", 64'(wr_valid), 64'd1);
    end
  endtask

  task automatic sacc(input bit sh, input bit cl, input string tag);
    @(negedge clk);
    wait_ready();
    cmd_valid = 1; cmd_mul = 0; cmd_shift = sh; cmd_clr = cl;
    if (sh) begin
      exp_q.push_back(m_acc[WORD_W-1:0]);
      tag_q.push_back(tag);
      m_acc = cl ? '0 : (m_acc >> WORD_W);
    end else if (cl) begin
      m_acc = '0;
    end
    @(negedge clk); cmd_valid = 0; cmd_shift = 0; cmd_clr = 0;
  endtask

  task automatic drain();
    int n = 0;
    while ((exp_q.size() != 0 || wr_valid) && n < 2000) begin
      @(negedge clk);
      n++;
    end
  endtask

  // watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      done = 1'b1;
      check(1'b0, "watchdog expired", 64'(cyc), 64'd0);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(wr_valid == 1'b0, "R1 wr_valid after reset", 64'(wr_valid), 64'd0);
    check(cmd_ready == 1'b1, "R1 cmd_ready after reset", 64'(cmd_ready), 64'd1);
    sacc(1, 0, "R1 accumulator zero after reset");
    drain();

    // R2: halves distinct in both operands
    mac(32'h1234_5678, 32'h9ABC_DEF0, 1, 1, "R2 product low word");
    sacc(1, 0, "R2 product high word");
    mac(32'hFFFF_0001, 32'h0001_FFFF, 0, 1, "R2");
    mac(32'h8000_0000, 32'h0000_0003, 1, 0, "R2 accumulate low word");
    sacc(1, 0, "R2 accumulate high word");
    drain();

    // R7: clear on a multiply replaces earlier content
    mac(32'hDEAD_BEEF, 32'hCAFE_F00D, 0, 0, "R7");
    mac(32'h0000_0005, 32'h0000_0007, 1, 1, "R7 clear on multiply");
    sacc(0, 1, "R7");
    sacc(1, 0, "R7 standalone clear");
    drain();

    // R11: command with valid low changes nothing
    mac(32'h0F0F_0F0F, 32'h7070_7070, 0, 1, "R11");
    @(negedge clk); cmd_mul = 0; cmd_shift = 1; cmd_clr = 1;
    @(negedge clk); cmd_mul = 1;
    @(negedge clk); cmd_mul = 0; cmd_shift = 0; cmd_clr = 0;
    sacc(1, 0, "R11 ignored command low word");
    sacc(1, 0, "R11 ignored command high word");
    drain();

    // R3: back-to-back, next B in the first multiply cycle, next A in the second
    begin
      logic [31:0] pa[4], pb[4];
      pa = '{32'hA5A5_1234, 32'h0000_FFFF, 32'h7FFF_8001, 32'h1357_9BDF};
      pb = '{32'h5A5A_4321, 32'hFFFF_0000, 32'h8001_7FFF, 32'hFDB9_7531};
      @(negedge clk); b_ld = 1; bus_data = pb[0];
      @(negedge clk); b_ld = 0; a_ld = 1; bus_data = pa[0];
      for (int k = 0; k < 4; k++) begin
        @(negedge clk);
        a_ld = 0;
        check(cmd_ready == 1'b1, "R3 ready every second cycle", 64'(cmd_ready), 64'd1);
        cmd_valid = 1; cmd_mul = 1; cmd_clr = (k == 0); cmd_shift = (k == 3);
        model_mul(pa[k], pb[k], k == 3, k == 0, "R3 pipelined column low");
        if (k < 3) begin b_ld = 1; bus_data = pb[k+1]; end
        @(negedge clk);
        cmd_valid = 0; cmd_mul = 0; cmd_clr = 0; cmd_shift = 0; b_ld = 0;
        if (k < 3) begin a_ld = 1; bus_data = pa[k+1]; end
      end
      @(negedge clk); a_ld = 0;
      sacc(1, 0, "R3 pipelined column high");
      sacc(1, 0, "R3 pipelined column carry");
      drain();
    end

    // R4: sixteen all-ones products keep their carries
    for (int k = 0; k < 16; k++) mac(32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, k == 0, "R4");
    sacc(1, 0, "R4 guard word0");
    sacc(1, 0, "R4 guard word1");
    sacc(1, 0, "R4 guard carry word");
    drain();

    // R8/R9/R10: back-pressure
    sacc(0, 1, "R8");
    mac(32'h0000_1111, 32'h0000_0001, 0, 0, "R8");
    @(negedge clk); rdy_force = 0;
    repeat (2) @(negedge clk);
    sacc(1, 0, "R8 held word");
    @(negedge clk);
    begin
      logic [31:0] held;
      held = wr_data;
      check(wr_valid == 1'b1, "R8 valid held", 64'(wr_valid), 64'd1);
      check(cmd_ready == 1'b0, "R9 ready low with word waiting", 64'(cmd_ready), 64'd0);
      cmd_valid = 1; cmd_mul = 0; cmd_shift = 1; cmd_clr = 1;   // refused
      repeat (3) @(negedge clk);
      cmd_valid = 0; cmd_shift = 0; cmd_clr = 0;
      check(wr_data == held, "R8 data held", 64'(wr_data), 64'(held));
      check(wr_valid == 1'b1, "R8 valid still held", 64'(wr_valid), 64'd1);
    end
    rdy_force = 1;
    repeat (3) @(negedge clk);
    check(wr_valid == 1'b0, "R10 valid drops after transfer", 64'(wr_valid), 64'd0);
    mac(32'h0000_0002, 32'h0000_0003, 1, 0, "R9 refused command left state");
    drain();

    // pseudo-random consumer with mixed commands
    rdy_mode = 1;
    for (int k = 0; k < 24; k++) begin
      logic [31:0] ra, rb;
      seed = nxt(seed); ra = seed;
      seed = nxt(seed); rb = seed;
      mac(ra, rb, (k % 3) == 2, (k % 6) == 0, "R5 random stream");
      if ((k % 5) == 4) sacc(1, 0, "R6 random stream shift");
    end
    sacc(1, 0, "R6 final shift");
    drain();
    rdy_mode = 0;
    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R5 all expected words seen", 64'(exp_q.size()), 64'd0);

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule